// File: doc/BRIEF.md
# Feature Header List Walker

This engine walks a chain of 64-bit feature headers that sit in a memory-mapped region. A single start request supplies a base byte address and a region length. The engine then reads one header at a time through a request/response read port, decodes it and hands out one record per feature. Each record carries the header's byte address, type code, ID and revision. After a record is taken, the engine adds the header's relative next-offset to the current address and reads the next header. The walk ends when a header has its end-of-list bit set, or when the chain is broken.

A container header with ID 0 is the management engine. For that header the engine also reads the engine's table of per-port offset registers before it emits the record. It returns a bit mask of the ports that are marked implemented. The engine reports ports only and never follows a port pointer.

When the walk ends, the engine raises a one-cycle done pulse and holds the number of records emitted. An error flag tells a clean end-of-list apart from a broken or misaligned chain.

Top module: `fhl_walker`

## Requirements
- R1: Each emitted record gives the header's byte address and its decoded fields: ID from bits 11:0, revision from bits 15:12 and type from bits 63:60.
- R2: A header with type 4 (container) and ID 0 starts NPORT extra reads, at header address + 0x38 + 8·n for n = 0..NPORT-1, before its record is emitted. Any other header (type 1 accelerator, type 3 private, type 4 with ID 1 port, and so on) causes no extra read.
- R3: In a management-engine record, bit n of the port mask is bit 60 of the port-n offset register. In every other record the port mask is zero. The remaining bits of the port registers (offset, BAR, access control) have no effect.
- R4: After a record is accepted, the next header is read at the current address plus the unsigned byte offset in bits 39:16.
- R5: A header with bit 40 set ends the walk with the error flag clear. done_o is high for exactly one cycle, and rec_cnt_o then equals the number of records accepted.
- R6: A header with bit 40 clear and a next-offset of zero ends the walk with the error flag set, after its own record.
- R7: If next address + 8 > base + length, the walk ends with the error flag set, after the current record. A next header that ends exactly at base + length is accepted.
- R8: If the base address or a next-offset is not a multiple of 8, or the length is below 8, the walk ends with the error flag set. A bad base or length issues no read and ends with a count of 0. Every read address is a multiple of 8.
- R9: A record is held valid with stable fields until rec_ready_i is high. No read is issued while a record is pending.
- R10: A read request holds its address stable until rd_rdy_i is high. Only one read is outstanding at a time.
- R11: A start request is ignored while a walk is in progress (busy_o high).
- R12: After reset the engine is idle: busy_o, rd_req_o, rec_valid_o and done_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, sampled while idle |
| base_i | input | AW | Byte address of the first header |
| len_i | input | AW | Region length in bytes |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | AW | Read byte address |
| rd_rdy_i | input | 1 | Read request accepted |
| rsp_vld_i | input | 1 | Read data valid |
| rsp_data_i | input | 64 | Read data |
| rec_valid_o | output | 1 | Record valid |
| rec_ready_i | input | 1 | Record consumer ready |
| rec_addr_o | output | AW | Header byte address |
| rec_type_o | output | 4 | Header type code |
| rec_id_o | output | 12 | Header ID |
| rec_rev_o | output | 4 | Header revision |
| rec_port_mask_o | output | NPORT | Implemented-port mask |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle end-of-walk pulse |
| err_o | output | 1 | Last walk ended in error |
| rec_cnt_o | output | CW | Records emitted by the last walk |

## Verification
The assertions check the handshake rules on every cycle. They confirm that a pending read holds its address, that a pending record holds its fields, and that read addresses stay aligned. They also confirm that done is a single-cycle pulse seen only while idle, and that non-engine records carry an empty port mask. Only the bench scenarios can show the rest, because each depends on memory contents and on the chain as a whole:
- the decoded field values;
- the extra reads made for the management engine;
- offset following;
- the error and no-error endings at the region boundary;
- zero and misaligned offsets;
- the count;
- that a start request made mid-walk is ignored.

// File: rtl/fhl_pkg.sv
package fhl_pkg;
    localparam int WORD_W    = 64;
    localparam int OFS_W     = 24;
    localparam int TYP_W     = 4;
    localparam int ID_W      = 12;
    localparam int REV_W     = 4;
    localparam int RSVD_W    = WORD_W - TYP_W - 1 - OFS_W - REV_W - ID_W;
    localparam int IMPL_BIT  = 60;
    localparam int PTAB_OFS  = 'h38;
    localparam int WORD_B    = 8;

    localparam logic [TYP_W-1:0] TYPE_ACC  = 4'd1;
    localparam logic [TYP_W-1:0] TYPE_PRIV = 4'd3;
    localparam logic [TYP_W-1:0] TYPE_CONT = 4'd4;
    localparam logic [ID_W-1:0]  ID_MGMT   = 12'd0;
    localparam logic [ID_W-1:0]  ID_PORT   = 12'd1;

    typedef struct packed {
        logic [TYP_W-1:0]  typ;
        logic [RSVD_W-1:0] rsvd;
        logic              eol;
        logic [OFS_W-1:0]  nxt;
        logic [REV_W-1:0]  rev;
        logic [ID_W-1:0]   id;
    } hdr_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_HREQ, ST_HWAIT, ST_PREQ, ST_PWAIT, ST_EMIT
    } st_t;
endpackage

// File: rtl/fhl_hdr_decode.sv
module fhl_hdr_decode
    import fhl_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output hdr_t              hdr_o,
    output logic              is_mgmt_o
);
    always_comb begin
        hdr_o     = hdr_t'(word_i);
        is_mgmt_o = (hdr_o.typ == TYPE_CONT) && (hdr_o.id == ID_MGMT);
    end
endmodule

// File: rtl/fhl_step_check.sv
module fhl_step_check
    import fhl_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0]    cur_i,
    input  logic [OFS_W-1:0] ofs_i,
    input  logic             eol_i,
    input  logic [AW:0]      lim_i,
    output logic [AW-1:0]    nxt_o,
    output logic             fin_o,
    output logic             bad_o
);
    localparam int EW = AW + 2;
    logic [EW-1:0] sum, tail;

    always_comb begin
        sum   = EW'(cur_i) + EW'(ofs_i);
        tail  = sum + EW'(WORD_B);
        nxt_o = sum[AW-1:0];
        fin_o = 1'b1;
        bad_o = 1'b0;
        if (eol_i) begin
            bad_o = 1'b0;
        end else if (ofs_i == '0) begin
            bad_o = 1'b1;
        end else if (ofs_i[2:0] != 3'b000) begin
            bad_o = 1'b1;
        end else if (tail > EW'(lim_i)) begin
            bad_o = 1'b1;
        end else begin
            fin_o = 1'b0;
        end
    end
endmodule

// File: rtl/fhl_walker.sv
module fhl_walker
    import fhl_pkg::*;
#(
    parameter int AW    = 32,
    parameter int NPORT = 4,
    parameter int CW    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [AW-1:0]     base_i,
    input  logic [AW-1:0]     len_i,
    output logic              rd_req_o,
    output logic [AW-1:0]     rd_addr_o,
    input  logic              rd_rdy_i,
    input  logic              rsp_vld_i,
    input  logic [63:0]       rsp_data_i,
    output logic              rec_valid_o,
    input  logic              rec_ready_i,
    output logic [AW-1:0]     rec_addr_o,
    output logic [3:0]        rec_type_o,
    output logic [11:0]       rec_id_o,
    output logic [3:0]        rec_rev_o,
    output logic [NPORT-1:0]  rec_port_mask_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [CW-1:0]     rec_cnt_o
);
    localparam int PIW = (NPORT > 1) ? $clog2(NPORT) : 1;
    localparam logic [PIW-1:0] PLAST = PIW'(NPORT - 1);

    typedef struct packed {
        st_t              st;
        logic [AW-1:0]    cur;
        logic [AW:0]      lim;
        hdr_t             hdr;
        logic [NPORT-1:0] mask;
        logic [PIW-1:0]   pidx;
        logic [CW-1:0]    cnt;
        logic             done;
        logic             err;
    } regs_t;

    regs_t q, d;
    hdr_t          dec;
    logic          dec_mgmt;
    logic [AW-1:0] step_nxt;
    logic          step_fin, step_bad;

    fhl_hdr_decode u_dec (
        .word_i    (rsp_data_i),
        .hdr_o     (dec),
        .is_mgmt_o (dec_mgmt)
    );

    fhl_step_check #(.AW(AW)) u_step (
        .cur_i (q.cur),
        .ofs_i (q.hdr.nxt),
        .eol_i (q.hdr.eol),
        .lim_i (q.lim),
        .nxt_o (step_nxt),
        .fin_o (step_fin),
        .bad_o (step_bad)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.cnt = '0;
                    d.err = 1'b0;
                    d.cur = base_i;
                    d.lim = {1'b0, base_i} + {1'b0, len_i};
                    if (base_i[2:0] != 3'b000 || len_i < AW'(WORD_B)) begin
                        d.err  = 1'b1;
                        d.done = 1'b1;
                    end else begin
                        d.st = ST_HREQ;
                    end
                end
            end
            ST_HREQ:  if (rd_rdy_i) d.st = ST_HWAIT;
            ST_HWAIT: begin
                if (rsp_vld_i) begin
                    d.hdr  = dec;
                    d.mask = '0;
                    d.pidx = '0;
                    d.st   = dec_mgmt ? ST_PREQ : ST_EMIT;
                end
            end
            ST_PREQ:  if (rd_rdy_i) d.st = ST_PWAIT;
            ST_PWAIT: begin
                if (rsp_vld_i) begin
                    d.mask[q.pidx] = rsp_data_i[IMPL_BIT];
                    if (q.pidx == PLAST) begin
                        d.st = ST_EMIT;
                    end else begin
                        d.pidx = q.pidx + 1'b1;
                        d.st   = ST_PREQ;
                    end
                end
            end
            ST_EMIT: begin
                if (rec_ready_i) begin
                    d.cnt = q.cnt + 1'b1;
                    if (step_fin) begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                        d.err  = step_bad;
                    end else begin
                        d.cur = step_nxt;
                        d.st  = ST_HREQ;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        rd_req_o  = (q.st == ST_HREQ) || (q.st == ST_PREQ);
        rd_addr_o = q.cur;
        if (q.st == ST_PREQ)
            rd_addr_o = q.cur + AW'(PTAB_OFS) + (AW'(q.pidx) << 3);
    end

    assign rec_valid_o     = (q.st == ST_EMIT);
    assign rec_addr_o      = q.cur;
    assign rec_type_o      = q.hdr.typ;
    assign rec_id_o        = q.hdr.id;
    assign rec_rev_o       = q.hdr.rev;
    assign rec_port_mask_o = q.mask;
    assign busy_o          = (q.st != ST_IDLE);
    assign done_o          = q.done;
    assign err_o           = q.err;
    assign rec_cnt_o       = q.cnt;

    a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o && !rd_rdy_i |=> rd_req_o && $stable(rd_addr_o));

    a_r9_rec_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid_o && !rec_ready_i |=> rec_valid_o && $stable(rec_addr_o)
            && $stable(rec_id_o) && $stable(rec_type_o) && $stable(rec_port_mask_o));

    a_r8_aligned_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> rd_addr_o[2:0] == 3'b000);

    a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o && !rec_valid_o);

    a_r3_mask_empty: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid_o && !(rec_type_o == TYPE_CONT && rec_id_o == ID_MGMT)
            |-> rec_port_mask_o == '0);
endmodule

// File: tb/sim_fhl_walker.sv
module sim_fhl_walker;
    localparam int CLK_P = 10;
    localparam int AW = 32;
    localparam int NP = 4;

    logic clk = 0, rst_n = 0;
    logic start = 0;
    logic [AW-1:0] base = 0, len = 0;
    logic rd_req, rd_rdy, rsp_vld = 0;
    logic [AW-1:0] rd_addr;
    logic [63:0] rsp_data = 0;
    logic rec_valid, rec_ready;
    logic [AW-1:0] rec_addr;
    logic [3:0] rec_type, rec_rev;
    logic [11:0] rec_id;
    logic [NP-1:0] rec_mask;
    logic busy, done, err;
    logic [7:0] cnt;

    int n_chk = 0, n_fail = 0;
    logic stall = 0, bp = 0, slow = 0, clr = 0;
    logic [31:0] cyc = 0;
    logic [63:0] mem [0:255];

    logic pend = 0;
    logic [AW-1:0] paddr = 0;
    logic [2:0] lat = 0;
    int rd_n = 0, ncap = 0;
    logic [AW-1:0] cap_a [0:7];
    logic [3:0] cap_t [0:7];
    logic [11:0] cap_i [0:7];
    logic [3:0] cap_r [0:7];
    logic [NP-1:0] cap_m [0:7];
    logic [AW-1:0] exp_a [0:7];
    logic [3:0] exp_t [0:7];
    logic [11:0] exp_i [0:7];
    logic [3:0] exp_r [0:7];
    logic [NP-1:0] exp_m [0:7];

    fhl_walker #(.AW(AW), .NPORT(NP), .CW(8)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .base_i(base), .len_i(len),
        .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_rdy_i(rd_rdy),
        .rsp_vld_i(rsp_vld), .rsp_data_i(rsp_data),
        .rec_valid_o(rec_valid), .rec_ready_i(rec_ready), .rec_addr_o(rec_addr),
        .rec_type_o(rec_type), .rec_id_o(rec_id), .rec_rev_o(rec_rev),
        .rec_port_mask_o(rec_mask), .busy_o(busy), .done_o(done), .err_o(err),
        .rec_cnt_o(cnt));

    always #(CLK_P/2) clk = ~clk;

    assign rd_rdy    = !stall || cyc[1];
    assign rec_ready = !bp || (cyc[1:0] == 2'b11);

    function automatic logic [63:0] rdm(input logic [AW-1:0] a);
        return (a < 32'h800) ? mem[a[10:3]] : 64'hDEAD_BEEF_0000_0000;
    endfunction

    function automatic logic [63:0] hdr(input logic [3:0] t, input logic [11:0] id,
        input logic [3:0] rv, input logic [23:0] ofs, input logic eol);
        return {t, 19'h0, eol, ofs, rv, id};
    endfunction

    always @(posedge clk) begin
        cyc     <= cyc + 1;
        rsp_vld <= 1'b0;
        if (clr) rd_n <= 0;
        if (pend) begin
            if (lat == 0) begin
                rsp_vld  <= 1'b1;
                rsp_data <= rdm(paddr);
                pend     <= 1'b0;
            end else lat <= lat - 1;
        end else if (rst_n && rd_req && rd_rdy) begin
            pend  <= 1'b1;
            paddr <= rd_addr;
            lat   <= slow ? rd_addr[5:3] : 3'd0;
            if (!clr) rd_n <= rd_n + 1;
        end
    end

    always @(posedge clk) begin
        if (clr) ncap <= 0;
        else if (rec_valid && rec_ready && ncap < 8) begin
            cap_a[ncap] <= rec_addr; cap_t[ncap] <= rec_type;
            cap_i[ncap] <= rec_id;   cap_r[ncap] <= rec_rev;
            cap_m[ncap] <= rec_mask; ncap <= ncap + 1;
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic setexp(input int k, input logic [AW-1:0] a, input logic [3:0] t,
        input logic [11:0] id, input logic [3:0] rv, input logic [NP-1:0] m);
        exp_a[k] = a; exp_t[k] = t; exp_i[k] = id; exp_r[k] = rv; exp_m[k] = m;
    endtask

    task automatic run(input logic [AW-1:0] b, input logic [AW-1:0] l, input int poke,
        output logic e, output logic [7:0] c);
        int g;
        @(negedge clk); start = 1; base = b; len = l; clr = 1;
        @(negedge clk); start = 0; clr = 0;
        g = 0;
        while (!done && g < 3000) begin
            @(negedge clk); g++;
            if (g == poke) begin start = 1; base = 32'h104; len = 32'h40; end
            else start = 0;
        end
        start = 0;
        chk(g < 3000, "R5 walk finishes", 64'(g), 64'd3000);
        e = err; c = cnt;
        @(negedge clk);
        chk(!done, "R5 done lasts one cycle", 64'(done), 64'd0);
    endtask

    task automatic cmp_recs(input int n, input string tag);
        chk(ncap == n, tag, 64'(ncap), 64'(n));
        for (int k = 0; k < n && k < ncap; k++) begin
            chk(cap_a[k] == exp_a[k], "R4 record address", 64'(cap_a[k]), 64'(exp_a[k]));
            chk({cap_t[k], cap_i[k], cap_r[k]} == {exp_t[k], exp_i[k], exp_r[k]},
                "R1 record fields", 64'({cap_t[k], cap_i[k], cap_r[k]}),
                64'({exp_t[k], exp_i[k], exp_r[k]}));
            chk(cap_m[k] == exp_m[k], "R3 port mask", 64'(cap_m[k]), 64'(exp_m[k]));
        end
    endtask

    task automatic t_reset;
        chk(!busy && !rd_req && !rec_valid && !done, "R12 reset idle",
            64'({busy, rd_req, rec_valid, done}), 64'd0);
    endtask

    task automatic set_main_exp;
        setexp(0, 32'h100, 4'd4, 12'h000, 4'd1, 4'b0101);
        setexp(1, 32'h200, 4'd4, 12'h001, 4'd2, 4'b0000);
        setexp(2, 32'h240, 4'd1, 12'h0FF, 4'd3, 4'b0000);
        setexp(3, 32'h280, 4'd3, 12'h010, 4'd4, 4'b0000);
    endtask

    task automatic t_chain(input logic s, input logic b, input logic sl, input string tag);
        logic e; logic [7:0] c;
        stall = s; bp = b; slow = sl;
        set_main_exp();
        run(32'h100, 32'h200, -1, e, c);
        chk(!e, {"R5 clean end ", tag}, 64'(e), 64'd0);
        chk(c == 8'd4, "R5 record count", 64'(c), 64'd4);
        chk(rd_n == 8, "R2 read count incl. port table", 64'(rd_n), 64'd8);
        cmp_recs(4, {"R9 records under handshake ", tag});
        stall = 0; bp = 0; slow = 0;
    endtask

    task automatic t_zero_ofs;
        logic e; logic [7:0] c;
        setexp(0, 32'h300, 4'd3, 12'h012, 4'd0, 4'b0);
        run(32'h300, 32'h100, -1, e, c);
        chk(e, "R6 zero offset error", 64'(e), 64'd1);
        chk(c == 8'd1, "R6 count", 64'(c), 64'd1);
        cmp_recs(1, "R6 records");
    endtask

    task automatic t_bound;
        logic e; logic [7:0] c;
        setexp(0, 32'h400, 4'd1, 12'h0FF, 4'd0, 4'b0);
        setexp(1, 32'h440, 4'd3, 12'h011, 4'd5, 4'b0);
        run(32'h400, 32'h48, -1, e, c);
        chk(!e && c == 8'd2, "R7 exact fit accepted", 64'({e, c}), 64'h2);
        cmp_recs(2, "R7 records exact fit");
        run(32'h400, 32'h47, -1, e, c);
        chk(e && c == 8'd1, "R7 overrun error", 64'({e, c}), 64'h101);
        cmp_recs(1, "R7 records overrun");
    endtask

    task automatic t_align;
        logic e; logic [7:0] c;
        run(32'h104, 32'h100, -1, e, c);
        chk(e && c == 0 && rd_n == 0, "R8 misaligned base",
            64'({e, c, 8'(rd_n)}), 64'h10000);
        run(32'h400, 32'h4, -1, e, c);
        chk(e && c == 0 && rd_n == 0, "R8 short length",
            64'({e, c, 8'(rd_n)}), 64'h10000);
        setexp(0, 32'h500, 4'd3, 12'h013, 4'd0, 4'b0);
        run(32'h500, 32'h100, -1, e, c);
        chk(e && c == 8'd1, "R8 misaligned offset", 64'({e, c}), 64'h101);
        cmp_recs(1, "R8 records");
    endtask

    task automatic t_busy_start;
        logic e; logic [7:0] c;
        slow = 1; stall = 1;
        set_main_exp();
        run(32'h100, 32'h200, 6, e, c);
        chk(!e && c == 8'd4, "R11 start ignored while busy", 64'({e, c}), 64'h4);
        cmp_recs(4, "R11 records unchanged");
        slow = 0; stall = 0;
    endtask

    initial begin
        for (int k = 0; k < 256; k++) mem[k] = 64'h0;
        mem['h100 >> 3] = hdr(4'd4, 12'h000, 4'd1, 24'h100, 1'b0);
        mem['h138 >> 3] = 64'h1080_0003_0000_0200;
        mem['h140 >> 3] = 64'h0080_0002_0000_0300;
        mem['h148 >> 3] = 64'h1000_0001_0000_0400;
        mem['h150 >> 3] = 64'h0F00_0000_0000_0000;
        mem['h200 >> 3] = hdr(4'd4, 12'h001, 4'd2, 24'h040, 1'b0);
        mem['h240 >> 3] = hdr(4'd1, 12'h0FF, 4'd3, 24'h040, 1'b0);
        mem['h280 >> 3] = hdr(4'd3, 12'h010, 4'd4, 24'h040, 1'b1);
        mem['h300 >> 3] = hdr(4'd3, 12'h012, 4'd0, 24'h000, 1'b0);
        mem['h400 >> 3] = hdr(4'd1, 12'h0FF, 4'd0, 24'h040, 1'b0);
        mem['h440 >> 3] = hdr(4'd3, 12'h011, 4'd5, 24'h008, 1'b1);
        mem['h500 >> 3] = hdr(4'd3, 12'h013, 4'd0, 24'h044, 1'b0);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_chain(0, 0, 0, "plain");
        t_chain(1, 1, 1, "stalled");
        t_zero_ofs();
        t_bound();
        t_align();
        t_busy_start();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule